// File: doc/BRIEF.md
# Serial Bit Stuffer and Destuffer for a Differential Field Bus

This block sits between a frame sequencer and the bus bit-timing logic of a multi-master field bus controller. Its transmit path takes the frame as a serial stream from a bit source. While stuffing is enabled, it inserts one complementary bit whenever five equal bits have gone onto the bus. During that insertion the source is stalled for one bit time. The receive path watches the sampled bus bits, removes the bit that follows five equal bits inside a stuffed region, and flags the case where that bit does not differ from the run.

Each path has its own stuffing-enable input, which the sequencer drives high from the start-of-frame bit through the end of the checksum sequence. It drives the enable low for the fixed-form tail and for error or overload signalling, so those bits pass unchanged. The run count includes the start-of-frame bit. The decision to stuff depends only on bits already sent, never on the next source bit, so transmitters with identical history insert identical stuff bits during contention.

A single-cycle strobe from the bit-timing logic marks each bit time, and nothing changes between strobes. A frame reset input clears both run counters between frames.

Top module: `can_stuff_codec`

## Requirements
- R1: At a strobe with `tx_ready` high, `tx_bit_out` takes the value of `tx_bit_in` one clock later and holds it until the next strobe. After reset or a frame reset, `tx_bit_out` is 1 (recessive).
- R2: With `tx_stuff_en` high, once five equal bits have been emitted (the first enabled bit, normally the dominant 0 start-of-frame, counts as bit one), `tx_ready` is low. The next strobe then emits the inverse of the last emitted bit and consumes no source bit.
- R3: An inserted stuff bit starts a new run of length one with its own value. Four further equal source bits after it bring `tx_ready` low again, and right after a stuff bit `tx_ready` is high.
- R4: While `tx_stuff_en` is low, `tx_ready` is high and no bit is ever inserted, whatever the run length.
- R5: A frame reset, or a clock with the path's stuffing enable low, clears that path's run count. A later run then starts counting from one.
- R6: With `rx_stuff_en` high, the strobed bit that follows five equal received bits is discarded. One clock after its strobe, `rx_stuff_drop` pulses and `rx_valid` stays low.
- R7: If that discarded bit equals the five before it, `rx_stuff_err` pulses together with `rx_stuff_drop`. The receive run then restarts at one with that bit's value.
- R8: Every other strobed receive bit, and every bit while `rx_stuff_en` is low, raises `rx_valid` for one clock after its strobe, with `rx_bit_out` equal to the sampled bit.
- R9: The pulses `rx_valid`, `rx_stuff_drop` and `rx_stuff_err` are low in any clock that does not follow a strobe. After reset, `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rst | input | 1 | Synchronous frame reset, clears both run counters |
| bit_strobe | input | 1 | One-clock pulse per bus bit time |
| tx_stuff_en | input | 1 | Transmit bits are in a stuffed field |
| tx_bit_in | input | 1 | Next frame bit from the bit source |
| tx_ready | output | 1 | Source bit is consumed at the next strobe |
| tx_bit_out | output | 1 | Bit driven toward the bus (1 = recessive) |
| rx_stuff_en | input | 1 | Receive bits are in a stuffed field |
| rx_bit_in | input | 1 | Sampled bus bit |
| rx_bit_out | output | 1 | Destuffed data bit |
| rx_valid | output | 1 | Pulse: `rx_bit_out` carries a real data bit |
| rx_stuff_drop | output | 1 | Pulse: a stuff bit was removed |
| rx_stuff_err | output | 1 | Pulse: the bit after five equal bits did not differ |

## Verification
On every cycle, the assertions check the following. A source bit passes through when ready. An inserted bit always inverts the previous bus bit, and it is always followed by a ready source. Ready never drops outside a stuffed field. A receive drop never coincides with a valid data bit, and every error is also a drop. Unstuffed receive bits always pass, and no pulse appears without a strobe. Whether a stuff bit lands after exactly five equal bits, and never earlier, depends on counting history. Only the bench's reference model shows this, over directed runs and biased random streams. The same applies to counting from the start-of-frame bit, the run restart after a stuff bit or an error, and clearing by frame reset or by dropping the enable.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

  // classification of one receive strobe
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_DATA  = 2'd1,
    RX_DROP  = 2'd2,
    RX_FAULT = 2'd3
  } rx_kind_e;

  // length of the equal-bit run after adding bit b to a run of cnt bits of value last
  function automatic int unsigned run_next(input int unsigned cnt, input logic last,
                                           input logic b, input int unsigned lim);
    if (cnt != 0 && b == last) begin
      return (cnt >= lim) ? lim : cnt + 1;
    end
    return 1;
  endfunction

  // how a strobed receive bit is handled given the current run state
  function automatic rx_kind_e rx_classify(input logic en, input logic full,
                                           input logic b, input logic last);
    if (!en || !full) return RX_DATA;
    if (b == last) return RX_FAULT;
    return RX_DROP;
  endfunction

endpackage

// File: rtl/can_run_track.sv
module can_run_track
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             restart,
  input  logic             bit_val,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_last,
  output logic             run_full
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (restart) cnt_nxt = CNT_W'(1);
    else         cnt_nxt = CNT_W'(run_next(int'(run_cnt), run_last, bit_val, RUN_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_last <= 1'b1;
    end else if (clr) begin
      run_cnt  <= '0;
      run_last <= 1'b1;
    end else if (step) begin
      run_cnt  <= cnt_nxt;
      run_last <= bit_val;
    end
  end

  assign run_full = (run_cnt == CNT_W'(RUN_LEN));

endmodule

// File: rtl/can_stuff_tx.sv
module can_stuff_tx #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rst,
  input  logic bit_strobe,
  input  logic stuff_en,
  input  logic src_bit,
  output logic src_ready,
  output logic bus_bit,
  output logic stuff_fire
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_last;
  logic             run_full;
  logic             stuff_due;
  logic             emit_bit;

  assign stuff_due  = stuff_en & run_full;
  assign src_ready  = ~stuff_due;
  assign emit_bit   = stuff_due ? ~run_last : src_bit;
  assign stuff_fire = bit_strobe & stuff_due & ~frame_rst;

  can_run_track #(.RUN_LEN(RUN_LEN)) i_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frame_rst | ~stuff_en),
    .step     (bit_strobe),
    .restart  (1'b0),
    .bit_val  (emit_bit),
    .run_cnt  (run_cnt),
    .run_last (run_last),
    .run_full (run_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bus_bit <= 1'b1;
    else if (frame_rst)  bus_bit <= 1'b1;
    else if (bit_strobe) bus_bit <= emit_bit;
  end

endmodule

// File: rtl/can_stuff_rx.sv
module can_stuff_rx
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rst,
  input  logic bit_strobe,
  input  logic stuff_en,
  input  logic bus_bit,
  output logic data_bit,
  output logic data_valid,
  output logic stuff_drop,
  output logic stuff_err,
  output logic run_full
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_last;
  rx_kind_e         kind;

  always_comb begin
    if (!bit_strobe || frame_rst) kind = RX_IDLE;
    else                          kind = rx_classify(stuff_en, run_full, bus_bit, run_last);
  end

  can_run_track #(.RUN_LEN(RUN_LEN)) i_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frame_rst | ~stuff_en),
    .step     (bit_strobe),
    .restart  (kind == RX_FAULT),
    .bit_val  (bus_bit),
    .run_cnt  (run_cnt),
    .run_last (run_last),
    .run_full (run_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_bit   <= 1'b1;
      data_valid <= 1'b0;
      stuff_drop <= 1'b0;
      stuff_err  <= 1'b0;
    end else begin
      data_valid <= (kind == RX_DATA);
      stuff_drop <= (kind == RX_DROP) || (kind == RX_FAULT);
      stuff_err  <= (kind == RX_FAULT);
      if (kind == RX_DATA) data_bit <= bus_bit;
    end
  end

endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rst,
  input  logic bit_strobe,
  input  logic tx_stuff_en,
  input  logic tx_bit_in,
  output logic tx_ready,
  output logic tx_bit_out,
  input  logic rx_stuff_en,
  input  logic rx_bit_in,
  output logic rx_bit_out,
  output logic rx_valid,
  output logic rx_stuff_drop,
  output logic rx_stuff_err
);

  // internal events, visible to the bound checker
  logic tx_stuff_fire;
  logic rx_run_full;

  can_stuff_tx #(.RUN_LEN(RUN_LEN)) i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_rst  (frame_rst),
    .bit_strobe (bit_strobe),
    .stuff_en   (tx_stuff_en),
    .src_bit    (tx_bit_in),
    .src_ready  (tx_ready),
    .bus_bit    (tx_bit_out),
    .stuff_fire (tx_stuff_fire)
  );

  can_stuff_rx #(.RUN_LEN(RUN_LEN)) i_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_rst  (frame_rst),
    .bit_strobe (bit_strobe),
    .stuff_en   (rx_stuff_en),
    .bus_bit    (rx_bit_in),
    .data_bit   (rx_bit_out),
    .data_valid (rx_valid),
    .stuff_drop (rx_stuff_drop),
    .stuff_err  (rx_stuff_err),
    .run_full   (rx_run_full)
  );

endmodule

// File: rtl/can_stuff_checker.sv
module can_stuff_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_rst,
  input logic bit_strobe,
  input logic tx_stuff_en,
  input logic tx_bit_in,
  input logic tx_ready,
  input logic tx_bit_out,
  input logic tx_stuff_fire,
  input logic rx_stuff_en,
  input logic rx_bit_in,
  input logic rx_bit_out,
  input logic rx_valid,
  input logic rx_stuff_drop,
  input logic rx_stuff_err,
  input logic rx_run_full
);

  p_tx_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && tx_ready && !frame_rst) |=> (tx_bit_out == $past(tx_bit_in)));

  p_stuff_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !tx_ready && !frame_rst) |=> (tx_bit_out != $past(tx_bit_out)));

  p_fire_in_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stuff_fire |-> tx_stuff_en);

  p_fresh_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !tx_ready && !frame_rst) |=> tx_ready);

  p_ready_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_stuff_en |-> tx_ready);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> (tx_ready && tx_bit_out));

  p_drop_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_drop |-> ($past(rx_run_full && rx_stuff_en && bit_strobe) && !rx_valid));

  p_err_is_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> rx_stuff_drop);

  p_plain_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !rx_stuff_en && !frame_rst) |=> (rx_valid && rx_bit_out == $past(rx_bit_in)));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> (!rx_valid && !rx_stuff_drop && !rx_stuff_err));

endmodule

bind can_stuff_codec can_stuff_checker i_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_rst     (frame_rst),
  .bit_strobe    (bit_strobe),
  .tx_stuff_en   (tx_stuff_en),
  .tx_bit_in     (tx_bit_in),
  .tx_ready      (tx_ready),
  .tx_bit_out    (tx_bit_out),
  .tx_stuff_fire (tx_stuff_fire),
  .rx_stuff_en   (rx_stuff_en),
  .rx_bit_in     (rx_bit_in),
  .rx_bit_out    (rx_bit_out),
  .rx_valid      (rx_valid),
  .rx_stuff_drop (rx_stuff_drop),
  .rx_stuff_err  (rx_stuff_err),
  .rx_run_full   (rx_run_full)
);

// File: tb/test_can_stuff_codec.sv
`timescale 1ns/1ps
module test_can_stuff_codec;

  localparam int RUN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_rst = 1'b0;
  logic bit_strobe = 1'b0;
  logic tx_stuff_en = 1'b0;
  logic tx_bit_in = 1'b1;
  logic rx_stuff_en = 1'b0;
  logic rx_bit_in = 1'b1;
  logic tx_ready, tx_bit_out, rx_bit_out, rx_valid, rx_stuff_drop, rx_stuff_err;

  int checks = 0;
  int errors = 0;

  // bench reference state
  int   tm_cnt = 0;
  logic tm_last = 1'b1;
  logic tm_stuff_run = 1'b0;
  logic consumed;
  int   rm_cnt = 0;
  logic rm_last = 1'b1;

  always #2.5 clk = ~clk;

  can_stuff_codec #(.RUN_LEN(RUN)) i_can_stuff_codec (
    .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst), .bit_strobe(bit_strobe),
    .tx_stuff_en(tx_stuff_en), .tx_bit_in(tx_bit_in), .tx_ready(tx_ready),
    .tx_bit_out(tx_bit_out), .rx_stuff_en(rx_stuff_en), .rx_bit_in(rx_bit_in),
    .rx_bit_out(rx_bit_out), .rx_valid(rx_valid), .rx_stuff_drop(rx_stuff_drop),
    .rx_stuff_err(rx_stuff_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // next run length after bit b, written from the run rule
  function automatic int grow(input int cnt, input logic last, input logic b);
    if (cnt > 0 && b == last) return cnt + 1;
    return 1;
  endfunction

  task automatic do_bit(input logic txb, input logic rxb, input logic txen, input logic rxen);
    logic exp_tx, stuffed, exp_rdy, tag3;
    logic exp_valid, exp_drop, exp_err;
    int   c_tx, c_rx;
    @(negedge clk);
    tx_bit_in = txb; rx_bit_in = rxb; tx_stuff_en = txen; rx_stuff_en = rxen;
    bit_strobe = 1'b1;
    #1;
    c_tx = txen ? tm_cnt : 0;
    exp_rdy = !(txen && c_tx == RUN);
    chk(txen ? "R2" : "R4", "tx_ready", int'(tx_ready), int'(exp_rdy));
    // transmit model
    tag3 = 1'b0;
    if (txen && c_tx == RUN) begin
      stuffed = 1'b1; exp_tx = ~tm_last; tag3 = tm_stuff_run;
      tm_last = exp_tx; tm_cnt = 1; tm_stuff_run = 1'b1;
    end else begin
      stuffed = 1'b0; exp_tx = txb;
      if (txen) begin
        tm_cnt = grow(c_tx, tm_last, txb);
        if (tm_cnt == 1) tm_stuff_run = 1'b0;
        tm_last = txb;
      end else begin
        tm_cnt = 0; tm_stuff_run = 1'b0;
      end
    end
    consumed = !stuffed;
    // receive model
    c_rx = rxen ? rm_cnt : 0;
    exp_valid = 1'b0; exp_drop = 1'b0; exp_err = 1'b0;
    if (rxen && c_rx == RUN) begin
      exp_drop = 1'b1; exp_err = (rxb == rm_last);
      rm_last = rxb; rm_cnt = 1;
    end else begin
      exp_valid = 1'b1;
      if (rxen) begin rm_cnt = grow(c_rx, rm_last, rxb); rm_last = rxb; end
      else rm_cnt = 0;
    end
    @(negedge clk);
    bit_strobe = 1'b0;
    chk(stuffed ? (tag3 ? "R3" : "R2") : "R1", "tx_bit_out", int'(tx_bit_out), int'(exp_tx));
    chk("R8", "rx_valid", int'(rx_valid), int'(exp_valid));
    chk("R6", "rx_stuff_drop", int'(rx_stuff_drop), int'(exp_drop));
    chk("R7", "rx_stuff_err", int'(rx_stuff_err), int'(exp_err));
    if (exp_valid) chk("R8", "rx_bit_out", int'(rx_bit_out), int'(rxb));
    @(negedge clk);
    chk("R9", "quiet pulses", int'({rx_valid, rx_stuff_drop, rx_stuff_err}), 0);
  endtask

  task automatic do_frame_rst();
    @(negedge clk);
    frame_rst = 1'b1;
    @(negedge clk);
    frame_rst = 1'b0;
    tm_cnt = 0; rm_cnt = 0; tm_stuff_run = 1'b0;
    chk("R5", "tx_bit_out after frame reset", int'(tx_bit_out), 1);
    chk("R5", "tx_ready after frame reset", int'(tx_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic src, rprev, ten, ren;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "tx_bit_out in reset", int'(tx_bit_out), 1);
    chk("R9", "rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx_ready after reset", int'(tx_ready), 1);

    // R2: start bit 0 plus four more 0 -> stuff 1 on both paths
    for (int i = 0; i < 5; i++) do_bit(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R2", "ready low after five equal", int'(tx_ready), 0);
    do_bit(1'b1, 1'b1, 1'b1, 1'b1);
    // R3: four 1s after the stuff 1 -> next stuff is 0
    for (int i = 0; i < 4; i++) do_bit(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R3", "ready low after stuff plus four", int'(tx_ready), 0);
    do_bit(1'b0, 1'b0, 1'b1, 1'b1);
    do_frame_rst();

    // R7: receive error, then restart at one
    for (int i = 0; i < 5; i++) do_bit(1'b0, 1'b1, 1'b1, 1'b1);
    do_bit(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) do_bit(1'b1, 1'b1, 1'b1, 1'b1);
    do_bit(1'b0, 1'b1, 1'b1, 1'b1);
    do_frame_rst();

    // R5: four equal, frame reset, four more -> no stuff
    for (int i = 0; i < 4; i++) do_bit(1'b0, 1'b0, 1'b1, 1'b1);
    do_frame_rst();
    for (int i = 0; i < 4; i++) do_bit(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", "ready high after cleared run", int'(tx_ready), 1);
    // R5: enable dropped for one bit clears the run
    do_bit(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_bit(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", "ready high after enable drop", int'(tx_ready), 1);
    // R4: long run with stuffing off
    for (int i = 0; i < 9; i++) do_bit(1'b1, 1'b1, 1'b0, 1'b0);
    do_frame_rst();

    // constrained random: biased runs, enables mostly high
    src = 1'b0; rprev = 1'b0;
    for (int ph = 0; ph < 30; ph++) begin
      ten = ($urandom % 5) != 0;
      ren = ($urandom % 5) != 0;
      for (int i = 0; i < 60; i++) begin
        rprev = (($urandom % 4) == 0) ? ~rprev : rprev;
        do_bit(src, rprev, ten, ren);
        if (consumed) src = (($urandom % 4) == 0) ? ~src : src;
        if (($urandom % 97) == 0) do_frame_rst();
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule